// File: doc/BRIEF.md
# Load-Delay Dependency Classifier

This block decides how the first instruction at a branch target interacts with a load that sat in the branch delay slot. It examines the upper half of the delay-slot word to see whether that instruction is a load-type operation. If it is, the block takes the loaded register index from its rt field. It then decodes the 32-bit target instruction and reports whether that instruction reads the loaded register, writes it, does both, or leaves it alone. An interpreter or trace checker uses the answer to pick how the stale and new register values must be sequenced.

Each accepted input produces one registered result one clock later, marked by a valid strobe. A two-state machine tracks whether the output stage holds a fresh result. `ST_IDLE` means no result was captured on the last edge. `ST_EMIT` means a result is being presented. The transition `TR_ACCEPT` (any state to `ST_EMIT`) fires when `in_valid` is high. The transition `TR_DRAIN` (any state to `ST_IDLE`) fires when `in_valid` is low. Back-to-back inputs keep the machine in `ST_EMIT`, and each input gets its own result.

Top module: `ldc_classifier`

## Requirements
- R1: While reset is held and on the first edge after it is released, `out_valid` is 0 and `out_class` is 0 (none).
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low otherwise. Consecutive inputs give consecutive results. Class encoding: 0 none, 1 read, 2 write, 3 read and write.
- R3: The check is armed (`out_armed`=1) only when the delay-slot opcode (`slot_upper[15:10]`) is 0x20 to 0x26 or 0x32, or is 0x10 with its rs field (`slot_upper[9:5]`) equal to 0x00 or 0x02. The loaded register is `slot_upper[4:0]`. When not armed, the class is none.
- R4: A target word of all zeros reports none, even when the loaded register is 0. A non-zero shift with rd=rt=0 against register 0 reports read and write.
- R5: Opcode 0 with funct 0x00, 0x02 or 0x03 (constant shifts) reads rt and writes rd. The rs field is ignored.
- R6: Opcode 0 with funct 0x04, 0x06, 0x07, 0x20 to 0x27, 0x2A or 0x2B reads rs and rt and writes rd.
- R7: Opcode 0 with funct 0x08 reads rs. Funct 0x09 reads rs and writes rd. Funct 0x10 and 0x12 write rd. Funct 0x11 and 0x13 read rs. Funct 0x18 to 0x1B read rs and rt.
- R8: Opcode 0x03 writes only when the loaded register equals the link register (31). Opcodes 0x04 and 0x05 read rs and rt. Opcodes 0x06 and 0x07 read rs. Opcode 0x01 reads rs only when its rt field is 0x00, 0x02, 0x10 or 0x12.
- R9: Opcodes 0x08 to 0x0E read rs and write rt. Opcode 0x0F writes rt and ignores rs.
- R10: Partial-word loads (opcodes 0x22 and 0x26) report read and write whenever rt matches, and read when only rs matches.
- R11: Loads 0x20, 0x21, 0x23, 0x24 and 0x25 read rs and write rt. Stores 0x28 to 0x2B and 0x2E read rs and rt and never write. Opcodes 0x32 and 0x3A read rs only.
- R12: Opcode 0x10 target with funct 0x04 or 0x06 reads rt. With funct 0x00 or 0x02 it writes rt. Any other funct reports none.
- R13: Any opcode or funct not listed above reports none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A slot/target pair is presented this cycle |
| slot_upper | input | 16 | Upper half of the delay-slot word: opcode, rs, rt |
| target_insn | input | 32 | Instruction word at the branch target |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_armed | output | 1 | The delay-slot instruction qualified for the check |
| out_class | output | 2 | Dependency class: 0 none, 1 read, 2 write, 3 both |

## Verification
For every instruction family, the target is tried with the loaded register placed in each operand field alone, then in a reading and a writing field together. This separates read, write and read-write, and exposes a wrong field being compared. Fields an instruction does not use, such as rs of a shift, rd of a register jump, and rs of an upper-immediate load, are loaded with the matching index to prove they are ignored. Register 0 against the all-zero word versus a non-zero shift, the link register against its neighbour, and unlisted rt, funct and opcode values probe the exception rules. Non-qualifying slot words, including a coprocessor move-to, and back-to-back versus gapped inputs check the arming and the strobe timing.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    localparam int WORD_W    = 32;
    localparam int OPC_W     = 6;
    localparam int FUN_W     = 6;
    localparam int REG_W     = 5;
    localparam int SLOT_W    = OPC_W + 2 * REG_W;
    localparam int OPC_LSB   = WORD_W - OPC_W;
    localparam int RS_LSB    = OPC_LSB - REG_W;
    localparam int RT_LSB    = RS_LSB - REG_W;
    localparam int RD_LSB    = RT_LSB - REG_W;

    // Primary opcodes consulted by the decoders
    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OPC_REGIMM  = 6'h01;
    localparam logic [OPC_W-1:0] OPC_CALL    = 6'h03;
    localparam logic [OPC_W-1:0] OPC_COP0    = 6'h10;
    localparam logic [OPC_W-1:0] OPC_LOAD_LO = 6'h20;
    localparam logic [OPC_W-1:0] OPC_LOAD_HI = 6'h26;
    localparam logic [OPC_W-1:0] OPC_CP2_LD  = 6'h32;

    typedef enum logic [1:0] {
        DEP_NONE  = 2'b00,
        DEP_READ  = 2'b01,
        DEP_WRITE = 2'b10,
        DEP_BOTH  = 2'b11
    } dep_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ldc_state_e;

    // Which operand fields of the target instruction are consumed or produced
    typedef struct packed {
        logic rd_rs;
        logic rd_rt;
        logic wr_rt;
        logic wr_rd;
        logic wr_link;
    } use_t;

endpackage

// File: rtl/ldc_trigger_decode.sv
module ldc_trigger_decode
    import ldc_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int RW = REG_W
) (
    input  logic [OW+2*RW-1:0] slot_upper,
    output logic               armed_o,
    output logic [RW-1:0]      load_reg_o
);

    localparam int OPC_TOP = OW + 2 * RW - 1;

    logic [OW-1:0] opc;
    logic [RW-1:0] sel;

    assign opc        = slot_upper[OPC_TOP -: OW];
    assign sel        = slot_upper[2*RW-1 -: RW];
    assign load_reg_o = slot_upper[RW-1:0];

    always_comb begin
        armed_o = 1'b0;
        if (opc >= OW'(OPC_LOAD_LO) && opc <= OW'(OPC_LOAD_HI)) begin
            armed_o = 1'b1;
        end else if (opc == OW'(OPC_CP2_LD)) begin
            armed_o = 1'b1;
        end else if (opc == OW'(OPC_COP0)) begin
            armed_o = (sel == RW'(0)) || (sel == RW'(2));
        end
    end

endmodule

// File: rtl/ldc_use_decode.sv
module ldc_use_decode
    import ldc_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [REG_W-1:0] rt_f,
    input  logic [FUN_W-1:0] funct,
    input  logic             is_zero,
    output use_t             use_o
);

    always_comb begin
        use_o = '0;
        unique case (opc)
            OPC_SPECIAL: begin
                if (!is_zero) begin
                    unique case (funct)
                        6'h00, 6'h02, 6'h03: begin
                            use_o.rd_rt = 1'b1;
                            use_o.wr_rd = 1'b1;
                        end
                        6'h04, 6'h06, 6'h07,
                        6'h20, 6'h21, 6'h22, 6'h23,
                        6'h24, 6'h25, 6'h26, 6'h27,
                        6'h2a, 6'h2b: begin
                            use_o.rd_rs = 1'b1;
                            use_o.rd_rt = 1'b1;
                            use_o.wr_rd = 1'b1;
                        end
                        6'h08: use_o.rd_rs = 1'b1;
                        6'h09: begin
                            use_o.rd_rs = 1'b1;
                            use_o.wr_rd = 1'b1;
                        end
                        6'h10, 6'h12: use_o.wr_rd = 1'b1;
                        6'h11, 6'h13: use_o.rd_rs = 1'b1;
                        6'h18, 6'h19, 6'h1a, 6'h1b: begin
                            use_o.rd_rs = 1'b1;
                            use_o.rd_rt = 1'b1;
                        end
                        default: use_o = '0;
                    endcase
                end
            end
            OPC_REGIMM: begin
                if (rt_f == 5'h00 || rt_f == 5'h02 || rt_f == 5'h10 || rt_f == 5'h12)
                    use_o.rd_rs = 1'b1;
            end
            OPC_CALL: use_o.wr_link = 1'b1;
            6'h04, 6'h05: begin
                use_o.rd_rs = 1'b1;
                use_o.rd_rt = 1'b1;
            end
            6'h06, 6'h07: use_o.rd_rs = 1'b1;
            6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0e: begin
                use_o.rd_rs = 1'b1;
                use_o.wr_rt = 1'b1;
            end
            6'h0f: use_o.wr_rt = 1'b1;
            OPC_COP0: begin
                unique case (funct)
                    6'h04, 6'h06: use_o.rd_rt = 1'b1;
                    6'h00, 6'h02: use_o.wr_rt = 1'b1;
                    default:      use_o = '0;
                endcase
            end
            6'h22, 6'h26: begin
                // merging loads consume the old rt contents as well
                use_o.rd_rs = 1'b1;
                use_o.rd_rt = 1'b1;
                use_o.wr_rt = 1'b1;
            end
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                use_o.rd_rs = 1'b1;
                use_o.wr_rt = 1'b1;
            end
            6'h28, 6'h29, 6'h2a, 6'h2b, 6'h2e: begin
                use_o.rd_rs = 1'b1;
                use_o.rd_rt = 1'b1;
            end
            6'h32, 6'h3a: use_o.rd_rs = 1'b1;
            default: use_o = '0;
        endcase
    end

    // R10: a merging load must be marked both reading and writing rt
    always_comb begin
        if (opc == 6'h22 || opc == 6'h26)
            a_r10_merge_rt_both: assert (use_o.rd_rt && use_o.wr_rt);
    end

endmodule

// File: rtl/ldc_class_merge.sv
module ldc_class_merge
    import ldc_pkg::*;
#(
    parameter int RW       = REG_W,
    parameter int LINK_REG = 31
) (
    input  use_t          use_i,
    input  logic [RW-1:0] rs_f,
    input  logic [RW-1:0] rt_f,
    input  logic [RW-1:0] rd_f,
    input  logic [RW-1:0] load_reg,
    input  logic          armed,
    output dep_class_e    class_o
);

    localparam logic [RW-1:0] LINK_IDX = RW'(LINK_REG);

    logic hit_rs, hit_rt, hit_rd, hit_link;
    logic reads, writes;

    assign hit_rs   = (rs_f == load_reg);
    assign hit_rt   = (rt_f == load_reg);
    assign hit_rd   = (rd_f == load_reg);
    assign hit_link = (load_reg == LINK_IDX);

    assign reads  = (use_i.rd_rs & hit_rs) | (use_i.rd_rt & hit_rt);
    assign writes = (use_i.wr_rt & hit_rt) | (use_i.wr_rd & hit_rd) |
                    (use_i.wr_link & hit_link);

    always_comb begin
        if (!armed)
            class_o = DEP_NONE;
        else
            class_o = dep_class_e'({writes, reads});
    end

endmodule

// File: rtl/ldc_classifier.sv
module ldc_classifier
    import ldc_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SLOT_W-1:0] slot_upper,
    input  logic [WORD_W-1:0] target_insn,
    output logic              out_valid,
    output logic              out_armed,
    output logic [1:0]        out_class
);

    logic [OPC_W-1:0] t_opc;
    logic [REG_W-1:0] t_rs, t_rt, t_rd;
    logic [FUN_W-1:0] t_fun;
    logic             t_zero;

    assign t_opc  = target_insn[OPC_LSB +: OPC_W];
    assign t_rs   = target_insn[RS_LSB +: REG_W];
    assign t_rt   = target_insn[RT_LSB +: REG_W];
    assign t_rd   = target_insn[RD_LSB +: REG_W];
    assign t_fun  = target_insn[FUN_W-1:0];
    assign t_zero = (target_insn == '0);

    logic             armed_c;
    logic [REG_W-1:0] load_reg_c;
    use_t             use_c;
    dep_class_e       class_c;

    ldc_trigger_decode #(.OW(OPC_W), .RW(REG_W)) trig_i (
        .slot_upper (slot_upper),
        .armed_o    (armed_c),
        .load_reg_o (load_reg_c)
    );

    ldc_use_decode use_i (
        .opc     (t_opc),
        .rt_f    (t_rt),
        .funct   (t_fun),
        .is_zero (t_zero),
        .use_o   (use_c)
    );

    ldc_class_merge #(.RW(REG_W), .LINK_REG(LINK_REG)) merge_i (
        .use_i    (use_c),
        .rs_f     (t_rs),
        .rt_f     (t_rt),
        .rd_f     (t_rd),
        .load_reg (load_reg_c),
        .armed    (armed_c),
        .class_o  (class_c)
    );

    // State register
    ldc_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    dep_class_e class_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_q <= DEP_NONE;
            armed_q <= 1'b0;
        end else if (in_valid) begin
            class_q <= class_c;
            armed_q <= armed_c;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_armed = armed_q;
    assign out_class = class_q;

    // R1: result stage is clear on the first edge out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_class == 2'b00));

    // R2: one strobe per accepted input, one cycle later
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: a non-qualifying slot never reports a dependency
    a_r3_unarmed_none: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_armed) |-> out_class == 2'b00);

    // R4: the all-zero word is a no-op
    a_r4_zero_none: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && target_insn == '0) |=> out_class == 2'b00);

    // R8: the call opcode never reads the loaded register
    a_r8_call_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && target_insn[OPC_LSB +: OPC_W] == OPC_CALL) |=> !out_class[0]);

    // R11: stores never write a register
    a_r11_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (target_insn[OPC_LSB +: OPC_W] inside {6'h28, 6'h29, 6'h2a, 6'h2b, 6'h2e}))
        |=> !out_class[1]);

endmodule

// File: tb/ldc_classifier_tb_top.sv
module ldc_classifier_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] slot_upper = '0;
    logic [31:0] target_insn = '0;
    logic        out_valid;
    logic        out_armed;
    logic [1:0]  out_class;

    always #2 clk = ~clk;

    ldc_classifier dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .slot_upper  (slot_upper),
        .target_insn (target_insn),
        .out_valid   (out_valid),
        .out_armed   (out_armed),
        .out_class   (out_class)
    );

    typedef struct {
        logic [2:0] exp;
        int         stamp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    localparam logic [1:0] N = 2'd0, RD = 2'd1, WR = 2'd2, RW = 2'd3;
    localparam logic [4:0] L = 5'd5;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rty(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sa,
                                        input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sa, fn};
    endfunction

    function automatic logic [31:0] ity(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt);
        return {op, rs, rt, 16'h0010};
    endfunction

    function automatic logic [31:0] c0(input logic [5:0] fn, input logic [4:0] rt);
        return {6'h10, 5'd0, rt, 5'd3, 5'd0, fn};
    endfunction

    function automatic logic [15:0] ld(input logic [5:0] op, input logic [4:0] rt);
        return {op, 5'd1, rt};
    endfunction

    task automatic send(input logic [15:0] su, input logic [31:0] ti,
                        input logic [1:0] ec, input logic ea, input string tag);
        item_t it;
        @(negedge clk);
        in_valid    = 1'b1;
        slot_upper  = su;
        target_insn = ti;
        it.exp   = {ea, ec};
        it.stamp = cyc;
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0].stamp < cyc) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (!out_valid) begin
                    failures++;
                    $display("FAIL R2 (%s): out_valid actual=0 expected=1", it.tag);
                end else if ({out_armed, out_class} !== it.exp) begin
                    failures++;
                    $display("FAIL %s: armed/class actual=%0d/%0d expected=%0d/%0d",
                             it.tag, out_armed, out_class, it.exp[2], it.exp[1:0]);
                end
            end else if (out_valid) begin
                checks++;
                failures++;
                $display("FAIL R2: out_valid actual=1 expected=0");
            end
        end
    end

    task automatic reset_check(input string tag);
        checks++;
        if (out_valid !== 1'b0 || out_class !== 2'b00) begin
            failures++;
            $display("FAIL R1 (%s): valid/class actual=%0d/%0d expected=0/0",
                     tag, out_valid, out_class);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        reset_check("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        reset_check("after release");

        // R3 arming
        send({6'h2b, 5'd1, L},           rty(0, 0, L, 0, 6'h21), N, 1'b0, "R3 store slot");
        send({6'h10, 5'd4, L},           rty(0, 0, L, 0, 6'h21), N, 1'b0, "R3 cop0 move-to slot");
        send({6'h10, 5'd0, L},           rty(0, 0, L, 0, 6'h21), WR, 1'b1, "R3 cop0 move-from slot");
        send({6'h10, 5'd2, L},           rty(L, 0, 0, 0, 6'h21), RD, 1'b1, "R3 cop0 ctl-from slot");
        send(ld(6'h32, L),               rty(L, 0, 0, 0, 6'h21), RD, 1'b1, "R3 cp2 load slot");
        send(ld(6'h27, L),               rty(L, 0, 0, 0, 6'h21), N, 1'b0, "R3 opcode 0x27 slot");
        gap();
        // R4
        send(ld(6'h23, 5'd0),            32'h0,                  N, 1'b1, "R4 zero word r0");
        send(ld(6'h23, 5'd0),            rty(0, 0, 0, 1, 6'h00), RW, 1'b1, "R4 shift r0 both");
        // R5
        send(ld(6'h23, L), rty(0, L, L, 2, 6'h03), RW, 1'b1, "R5 sra rd=rt");
        send(ld(6'h23, L), rty(0, L, 6, 2, 6'h02), RD, 1'b1, "R5 srl rt");
        send(ld(6'h23, L), rty(0, 7, L, 2, 6'h00), WR, 1'b1, "R5 sll rd");
        send(ld(6'h23, L), rty(L, 1, 2, 2, 6'h02), N, 1'b1, "R5 shift rs ignored");
        gap();
        // R6
        send(ld(6'h20, L), rty(L, 1, L, 0, 6'h21), RW, 1'b1, "R6 addu rd+rs");
        send(ld(6'h20, L), rty(L, 1, 2, 0, 6'h2b), RD, 1'b1, "R6 sltu rs");
        send(ld(6'h20, L), rty(1, L, 2, 0, 6'h27), RD, 1'b1, "R6 nor rt");
        send(ld(6'h20, L), rty(1, 2, L, 0, 6'h04), WR, 1'b1, "R6 sllv rd");
        send(ld(6'h20, L), rty(1, L, L, 0, 6'h2a), RW, 1'b1, "R6 slt rd+rt");
        // R7
        send(ld(6'h21, L), rty(L, 0, 0, 0, 6'h08), RD, 1'b1, "R7 jr rs");
        send(ld(6'h21, L), rty(1, 0, L, 0, 6'h08), N, 1'b1, "R7 jr rd ignored");
        send(ld(6'h21, L), rty(L, 0, L, 0, 6'h09), RW, 1'b1, "R7 jalr both");
        send(ld(6'h21, L), rty(1, 0, L, 0, 6'h09), WR, 1'b1, "R7 jalr rd");
        send(ld(6'h21, L), rty(0, 0, L, 0, 6'h10), WR, 1'b1, "R7 mfhi");
        send(ld(6'h21, L), rty(L, 0, 0, 0, 6'h13), RD, 1'b1, "R7 mtlo");
        send(ld(6'h21, L), rty(1, L, 0, 0, 6'h18), RD, 1'b1, "R7 mult rt");
        send(ld(6'h21, L), rty(L, 1, L, 0, 6'h1b), RD, 1'b1, "R7 divu rd ignored");
        gap();
        // R8
        send(ld(6'h23, 5'd31), {6'h03, 26'h0000123}, WR, 1'b1, "R8 call link r31");
        send(ld(6'h23, 5'd30), {6'h03, 26'h3ff0000}, N, 1'b1, "R8 call r30");
        send(ld(6'h23, L), ity(6'h04, 1, L), RD, 1'b1, "R8 beq rt");
        send(ld(6'h23, L), ity(6'h07, 1, L), N, 1'b1, "R8 bgtz rt ignored");
        send(ld(6'h23, L), ity(6'h07, L, 0), RD, 1'b1, "R8 bgtz rs");
        send(ld(6'h23, L), ity(6'h01, L, 5'h10), RD, 1'b1, "R8 regimm rt=0x10");
        send(ld(6'h23, L), ity(6'h01, L, 5'h01), N, 1'b1, "R8 regimm rt=0x01");
        gap();
        // R9
        send(ld(6'h24, L), ity(6'h09, L, L), RW, 1'b1, "R9 addiu both");
        send(ld(6'h24, L), ity(6'h0d, L, 6), RD, 1'b1, "R9 ori rs");
        send(ld(6'h24, L), ity(6'h0a, 1, L), WR, 1'b1, "R9 slti rt");
        send(ld(6'h24, L), ity(6'h0f, 0, L), WR, 1'b1, "R9 lui rt");
        send(ld(6'h24, L), ity(6'h0f, L, 6), N, 1'b1, "R9 lui rs ignored");
        // R10
        send(ld(6'h22, L), ity(6'h22, 1, L), RW, 1'b1, "R10 merge-left rt");
        send(ld(6'h22, L), ity(6'h26, L, 1), RD, 1'b1, "R10 merge-right rs");
        send(ld(6'h26, L), ity(6'h26, L, L), RW, 1'b1, "R10 merge-right both");
        gap();
        // R11
        send(ld(6'h25, L), ity(6'h20, 1, L), WR, 1'b1, "R11 byte load rt");
        send(ld(6'h25, L), ity(6'h25, L, L), RW, 1'b1, "R11 half load both");
        send(ld(6'h25, L), ity(6'h2b, 1, L), RD, 1'b1, "R11 word store rt");
        send(ld(6'h25, L), ity(6'h2e, L, 1), RD, 1'b1, "R11 store-right rs");
        send(ld(6'h25, L), ity(6'h3a, L, 1), RD, 1'b1, "R11 cp2 store rs");
        send(ld(6'h25, L), ity(6'h32, 1, L), N, 1'b1, "R11 cp2 load rt ignored");
        // R12
        send(ld(6'h23, L), c0(6'h04, L), RD, 1'b1, "R12 cop0 move-to");
        send(ld(6'h23, L), c0(6'h00, L), WR, 1'b1, "R12 cop0 move-from");
        send(ld(6'h23, L), c0(6'h10, L), N, 1'b1, "R12 cop0 other funct");
        gap();
        // R13
        send(ld(6'h23, L), {6'h11, L, L, L, 11'h0}, N, 1'b1, "R13 opcode 0x11");
        send(ld(6'h23, L), rty(L, L, L, 0, 6'h28), N, 1'b1, "R13 funct 0x28");
        send(ld(6'h23, L), {6'h02, 26'h0000005},     N, 1'b1, "R13 plain jump");
        gap();
        repeat (4) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2: pending results actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule